// File: doc/BRIEF.md
# Interleaved I/Q Input Data Demultiplexer

This block captures the sample words that feed a dual-channel transmit path and hands them on as sample-aligned I/Q pairs. It has two capture modes. In two-port mode, an I word on `port_a` and a Q word on `port_b` are taken on every clock. In one-port mode, only `port_a` carries data. I and Q words alternate on it, and the top bit of `port_b` becomes a select line that steers each word to the I or the Q half of a pair.

In one-port mode the block drives a port clock at half the core clock rate. That is twice the rate of the pairs it delivers, so a data source can launch one word per port-clock period. Configuration inputs control four things: the sense of the select line, the polarity of the port clock (which also moves the capture cycle), whether a pair opens with its I word or its Q word, and whether incoming words are signed or offset binary. Offset-binary words are turned into two's complement. A finished pair comes out on registered outputs with a one-cycle valid pulse.

Configuration inputs are expected to stay static between resets.

Top module: `iq_capture`

## Requirements
- R1: With `cfg_one_port`=0 (two-port mode), every clock edge captures `port_a` as I and all DATA_W bits of `port_b` as Q, including its top bit. The pair appears on `pair_i`/`pair_q` with `pair_valid`=1 right after that same edge, on every cycle.
- R2: With `cfg_one_port`=1 and `cfg_pclk_invert`=0, `port_clk_out` is 0 in the first cycle after reset and then toggles every clock cycle. With `cfg_one_port`=0 it stays 0.
- R3: In one-port mode, a word is captured only at the clock edge that ends a cycle in which `port_clk_out` is 1. Words present in other cycles are ignored. `cfg_pclk_invert`=1 inverts `port_clk_out`, so it is 1 in the first cycle after reset, and capture moves to the other phase.
- R4: In one-port mode, the select level is `port_b[DATA_W-1]` XOR `cfg_sel_invert`. A level of 1 routes the captured word to the I half and 0 routes it to the Q half.
- R5: With `cfg_q_first`=0, a captured I word becomes pending. A following captured Q word then completes the pair (I = pending word, Q = new word) and clears the pending state. A Q word that arrives with nothing pending is discarded.
- R6: With `cfg_q_first`=1 the roles are swapped. A Q word becomes pending and a following I word completes the pair. An I word that arrives with nothing pending is discarded.
- R7: In one-port mode, a second captured word with the same select level as the pending word replaces it, and no pair is emitted.
- R8: With `cfg_fmt_unsigned`=1, the top bit of every captured word is inverted (offset binary to two's complement), in both modes. With 0, words pass through unchanged.
- R9: `pair_valid` is a single-cycle pulse per completed pair. `pair_i` and `pair_q` change only together with it and otherwise hold the last pair.
- R10: Synchronous active-high `rst` clears `pair_valid`, `pair_i`, `pair_q`, the pending half and the port-clock phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_one_port | input | 1 | 0 = two-port capture, 1 = one-port interleaved capture |
| cfg_sel_invert | input | 1 | Inverts the sense of the select line |
| cfg_pclk_invert | input | 1 | Inverts the port clock and shifts the capture phase |
| cfg_q_first | input | 1 | 0 = pair opens with I, 1 = pair opens with Q |
| cfg_fmt_unsigned | input | 1 | 0 = two's complement input, 1 = offset binary input |
| port_a | input | DATA_W | I data (two-port) or interleaved data (one-port) |
| port_b | input | DATA_W | Q data (two-port); its top bit is the select line in one-port mode |
| port_clk_out | output | 1 | Half-rate port clock in one-port mode |
| pair_valid | output | 1 | One-cycle pulse when a pair is presented |
| pair_i | output | DATA_W | I word of the presented pair |
| pair_q | output | DATA_W | Q word of the presented pair |

## Verification
Two functions can land on the same edge. A word that completes a pair is captured, and in that same cycle the pending half is released and the output registers load. Because of this, the replace-pending path and the complete-pair path must never both act at once. The bench provokes this by driving, in the non-capture cycle just before each completing word, a junk word whose select level is the opposite of the following word. If the junk word were captured, it would replace the pending half or complete a pair early, and the pair then checked against the expected I and Q words would be wrong.

// File: rtl/iqd_pkg.sv
package iqd_pkg;
  // Which half of an I/Q pair a captured word belongs to.
  typedef enum logic {
    HALF_Q = 1'b0,
    HALF_I = 1'b1
  } half_e;
endpackage

// File: rtl/iqd_port_clock.sv
// Half-rate port clock and capture strobe for one-port mode.
module iqd_port_clock (
  input  logic clk,
  input  logic rst,
  input  logic one_port,
  input  logic pclk_invert,
  output logic capture_en,
  output logic port_clk
);
  logic phase_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= 1'b0;
    end else if (one_port) begin
      phase_q <= ~phase_q;
    end else begin
      phase_q <= 1'b0;
    end
  end

  // The port clock is high in the cycles whose closing edge captures a word.
  assign port_clk   = one_port & (phase_q ^ pclk_invert);
  assign capture_en = one_port ? port_clk : 1'b1;
endmodule

// File: rtl/iqd_word_format.sv
// Per-lane conversion from offset binary to two's complement.
module iqd_word_format #(
  parameter int DATA_W = 12,
  parameter int LANES  = 2
) (
  input  logic                          fmt_unsigned,
  input  logic [LANES-1:0][DATA_W-1:0]  raw,
  output logic [LANES-1:0][DATA_W-1:0]  conv
);
  localparam logic [DATA_W-1:0] TOP_MASK = {1'b1, {(DATA_W-1){1'b0}}};

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign conv[g] = fmt_unsigned ? (raw[g] ^ TOP_MASK) : raw[g];
  end
endmodule

// File: rtl/iqd_pair_assembler.sv
// Holds the pending half in one-port mode and registers finished pairs.
module iqd_pair_assembler
  import iqd_pkg::*;
#(
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              one_port,
  input  logic              q_first,
  input  logic              capture_en,
  input  half_e             half,
  input  logic [DATA_W-1:0] word_a,
  input  logic [DATA_W-1:0] word_b,
  output logic              pair_valid,
  output logic [DATA_W-1:0] pair_i,
  output logic [DATA_W-1:0] pair_q
);
  logic [DATA_W-1:0] pend_q, pend_n;
  logic              pend_vld_q, pend_vld_n;
  logic              emit;
  logic [DATA_W-1:0] emit_i, emit_q;
  half_e             open_half;

  assign open_half = q_first ? HALF_Q : HALF_I;

  always_comb begin
    pend_n     = pend_q;
    pend_vld_n = pend_vld_q;
    emit       = 1'b0;
    emit_i     = word_a;
    emit_q     = word_b;
    if (!one_port) begin
      emit       = 1'b1;
      pend_vld_n = 1'b0;
    end else if (capture_en) begin
      if (half == open_half) begin
        // Opening half: start or replace the pending word.
        pend_n     = word_a;
        pend_vld_n = 1'b1;
      end else if (pend_vld_q) begin
        // Closing half with a pending partner: the pair is complete.
        emit       = 1'b1;
        pend_vld_n = 1'b0;
        if (open_half == HALF_I) begin
          emit_i = pend_q;
          emit_q = word_a;
        end else begin
          emit_i = word_a;
          emit_q = pend_q;
        end
      end
      // A closing half with nothing pending is dropped.
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q     <= '0;
      pend_vld_q <= 1'b0;
      pair_valid <= 1'b0;
      pair_i     <= '0;
      pair_q     <= '0;
    end else begin
      pend_q     <= pend_n;
      pend_vld_q <= pend_vld_n;
      pair_valid <= emit;
      if (emit) begin
        pair_i <= emit_i;
        pair_q <= emit_q;
      end
    end
  end
endmodule

// File: rtl/iq_capture.sv
// Top: two-port or interleaved one-port I/Q capture with pair alignment.
module iq_capture
  import iqd_pkg::*;
#(
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_one_port,
  input  logic              cfg_sel_invert,
  input  logic              cfg_pclk_invert,
  input  logic              cfg_q_first,
  input  logic              cfg_fmt_unsigned,
  input  logic [DATA_W-1:0] port_a,
  input  logic [DATA_W-1:0] port_b,
  output logic              port_clk_out,
  output logic              pair_valid,
  output logic [DATA_W-1:0] pair_i,
  output logic [DATA_W-1:0] pair_q
);
  localparam int LANES  = 2;
  localparam int SEL_BIT = DATA_W - 1;

  logic                         capture_en;
  logic [LANES-1:0][DATA_W-1:0] raw_words;
  logic [LANES-1:0][DATA_W-1:0] conv_words;
  half_e                        word_half;

  iqd_port_clock u_pclk (
    .clk         (clk),
    .rst         (rst),
    .one_port    (cfg_one_port),
    .pclk_invert (cfg_pclk_invert),
    .capture_en  (capture_en),
    .port_clk    (port_clk_out)
  );

  assign raw_words[0] = port_a;
  assign raw_words[1] = port_b;

  iqd_word_format #(.DATA_W(DATA_W), .LANES(LANES)) u_fmt (
    .fmt_unsigned (cfg_fmt_unsigned),
    .raw          (raw_words),
    .conv         (conv_words)
  );

  // Select line: top bit of the second port, taken before conversion.
  assign word_half = (port_b[SEL_BIT] ^ cfg_sel_invert) ? HALF_I : HALF_Q;

  iqd_pair_assembler #(.DATA_W(DATA_W)) u_asm (
    .clk        (clk),
    .rst        (rst),
    .one_port   (cfg_one_port),
    .q_first    (cfg_q_first),
    .capture_en (capture_en),
    .half       (word_half),
    .word_a     (conv_words[0]),
    .word_b     (conv_words[1]),
    .pair_valid (pair_valid),
    .pair_i     (pair_i),
    .pair_q     (pair_q)
  );
endmodule

// File: rtl/iqd_checker.sv
module iqd_checker #(
  parameter int DATA_W = 12
) (
  input logic              clk,
  input logic              rst,
  input logic              cfg_one_port,
  input logic              cfg_pclk_invert,
  input logic              cfg_fmt_unsigned,
  input logic [DATA_W-1:0] port_a,
  input logic [DATA_W-1:0] port_b,
  input logic              port_clk_out,
  input logic              pair_valid,
  input logic [DATA_W-1:0] pair_i,
  input logic [DATA_W-1:0] pair_q
);
  AST_TWO_PORT_EVERY_CYCLE: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(!cfg_one_port)) |-> pair_valid); // R1

  AST_TWO_PORT_I_DATA: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(!cfg_one_port)) |->
      (pair_i == ($past(port_a) ^ {$past(cfg_fmt_unsigned), {(DATA_W-1){1'b0}}}))); // R8

  AST_TWO_PORT_Q_DATA: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(!cfg_one_port)) |->
      (pair_q == ($past(port_b) ^ {$past(cfg_fmt_unsigned), {(DATA_W-1){1'b0}}}))); // R1

  AST_PCLK_TOGGLES: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && cfg_one_port && $past(cfg_one_port) && $stable(cfg_pclk_invert))
      |-> (port_clk_out != $past(port_clk_out))); // R2

  AST_PCLK_IDLE_TWO_PORT: assert property (@(posedge clk) disable iff (rst)
    !cfg_one_port |-> !port_clk_out); // R2

  AST_PAIR_ON_STROBE: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(cfg_one_port) && pair_valid) |-> $past(port_clk_out)); // R3

  AST_PAIR_HOLD: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && !pair_valid) |-> ($stable(pair_i) && $stable(pair_q))); // R9
endmodule

bind iq_capture iqd_checker #(.DATA_W(DATA_W)) u_iqd_checker (
  .clk              (clk),
  .rst              (rst),
  .cfg_one_port     (cfg_one_port),
  .cfg_pclk_invert  (cfg_pclk_invert),
  .cfg_fmt_unsigned (cfg_fmt_unsigned),
  .port_a           (port_a),
  .port_b           (port_b),
  .port_clk_out     (port_clk_out),
  .pair_valid       (pair_valid),
  .pair_i           (pair_i),
  .pair_q           (pair_q)
);

// File: tb/test_iq_capture.sv
`timescale 1ns/1ps
module test_iq_capture;
  localparam int W = 12;
  localparam int NVEC = 15;
  // {cfg: unsigned, q_first, sel_invert}, sel, word, exp_valid, exp_i, exp_q
  localparam logic [40:0] VEC [NVEC] = '{
    {3'b000, 1'b1, 12'h123, 1'b0, 12'h000, 12'h000},  // R5 open I
    {3'b000, 1'b0, 12'h456, 1'b1, 12'h123, 12'h456},  // R5 close
    {3'b000, 1'b0, 12'h777, 1'b0, 12'h000, 12'h000},  // R5 lone Q dropped
    {3'b000, 1'b1, 12'h111, 1'b0, 12'h000, 12'h000},
    {3'b000, 1'b1, 12'h222, 1'b0, 12'h000, 12'h000},  // R7 replace
    {3'b000, 1'b0, 12'h333, 1'b1, 12'h222, 12'h333},  // R7
    {3'b010, 1'b0, 12'hA00, 1'b0, 12'h000, 12'h000},  // R6 open Q
    {3'b010, 1'b1, 12'h0B0, 1'b1, 12'h0B0, 12'hA00},  // R6 close
    {3'b010, 1'b1, 12'h001, 1'b0, 12'h000, 12'h000},  // R6 lone I dropped
    {3'b001, 1'b0, 12'h010, 1'b0, 12'h000, 12'h000},  // R4 inverted: pin 0 = I
    {3'b001, 1'b1, 12'h020, 1'b1, 12'h010, 12'h020},  // R4
    {3'b100, 1'b1, 12'h000, 1'b0, 12'h000, 12'h000},  // R8
    {3'b100, 1'b0, 12'hFFF, 1'b1, 12'h800, 12'h7FF},  // R8
    {3'b100, 1'b1, 12'h800, 1'b0, 12'h000, 12'h000},
    {3'b100, 1'b0, 12'h7FF, 1'b1, 12'h000, 12'hFFF}   // R8
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_one_port = 1'b1, cfg_sel_invert = 1'b0, cfg_pclk_invert = 1'b0;
  logic cfg_q_first = 1'b0, cfg_fmt_unsigned = 1'b0;
  logic [W-1:0] port_a = '0, port_b = '0;
  logic port_clk_out, pair_valid;
  logic [W-1:0] pair_i, pair_q;
  int total = 0, bad = 0;
  logic finished = 1'b0;

  always #5 clk = ~clk;

  iq_capture #(.DATA_W(W)) i_iq_capture (
    .clk(clk), .rst(rst), .cfg_one_port(cfg_one_port), .cfg_sel_invert(cfg_sel_invert),
    .cfg_pclk_invert(cfg_pclk_invert), .cfg_q_first(cfg_q_first),
    .cfg_fmt_unsigned(cfg_fmt_unsigned), .port_a(port_a), .port_b(port_b),
    .port_clk_out(port_clk_out), .pair_valid(pair_valid), .pair_i(pair_i), .pair_q(pair_q)
  );

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic one, input logic [2:0] cfg, input logic pinv);
    cfg_one_port = one; cfg_fmt_unsigned = cfg[2]; cfg_q_first = cfg[1];
    cfg_sel_invert = cfg[0]; cfg_pclk_invert = pinv;
    rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic step;
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    logic [2:0] prev_cfg;
    logic [W-1:0] hold_i, hold_q;
    // R10 reset state, R2 phase after reset
    do_reset(1'b1, 3'b000, 1'b0);
    check("R10 valid after reset", W'(pair_valid), 12'h0);
    check("R10 pair_i after reset", pair_i, 12'h0);
    check("R10 pair_q after reset", pair_q, 12'h0);
    for (int k = 0; k < 4; k++) begin
      check("R2 port clock toggles", W'(port_clk_out), W'(k % 2));
      step();
    end

    // Vector table: one-port sequences
    prev_cfg = 3'bxxx;
    hold_i = '0; hold_q = '0;
    for (int v = 0; v < NVEC; v++) begin
      logic [2:0] cfg; logic sel; logic [W-1:0] word, ei, eq; logic ev;
      {cfg, sel, word, ev, ei, eq} = VEC[v];
      if (cfg !== prev_cfg) begin
        do_reset(1'b1, cfg, 1'b0);
        prev_cfg = cfg; hold_i = '0; hold_q = '0;
      end
      if (!port_clk_out) begin
        port_a = 12'hBAD; port_b = {~sel, 11'h2AA};  // junk, must be ignored (R3)
        step();
        check("R9 single-cycle valid", W'(pair_valid), 12'h0);
      end
      port_a = word; port_b = {sel, 11'h5A5};
      step();
      check($sformatf("vec %0d valid", v), W'(pair_valid), W'(ev));
      if (ev) begin
        hold_i = ei; hold_q = eq;
      end
      check($sformatf("R9 vec %0d pair_i", v), pair_i, hold_i);
      check($sformatf("R9 vec %0d pair_q", v), pair_q, hold_q);
    end

    // R3: inverted port clock moves the capture phase
    do_reset(1'b1, 3'b000, 1'b1);
    check("R3 inverted clock high after reset", W'(port_clk_out), 12'h1);
    port_a = 12'h321; port_b = {1'b1, 11'h0};
    step();
    check("R3 clock low second cycle", W'(port_clk_out), 12'h0);
    port_a = 12'hBAD; port_b = {1'b1, 11'h0};
    step();
    check("R3 no pair on off phase", W'(pair_valid), 12'h0);
    port_a = 12'h654; port_b = {1'b0, 11'h0};
    step();
    check("R3 valid", W'(pair_valid), 12'h1);
    check("R3 pair_i", pair_i, 12'h321);
    check("R3 pair_q", pair_q, 12'h654);

    // R1: two-port mode, select config irrelevant, port_b MSB is data
    do_reset(1'b0, 3'b011, 1'b0);
    for (int k = 0; k < 3; k++) begin
      check("R2 port clock idle in two-port", W'(port_clk_out), 12'h0);
      port_a = 12'h135 + W'(k); port_b = 12'hF0F - W'(k);
      step();
      check("R1 two-port valid", W'(pair_valid), 12'h1);
      check("R1 two-port I", pair_i, 12'h135 + W'(k));
      check("R1 two-port Q", pair_q, 12'hF0F - W'(k));
    end

    // R8: unsigned conversion in two-port mode
    do_reset(1'b0, 3'b100, 1'b0);
    port_a = 12'h000; port_b = 12'hFFF;
    step();
    check("R8 two-port I converted", pair_i, 12'h800);
    check("R8 two-port Q converted", pair_q, 12'h7FF);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule